// File: doc/BRIEF.md
# QP-Driven 4x4 Coefficient Quantizer

This block turns a 4x4 block of signed integer-transform coefficients into sixteen signed quantized levels. The whole block arrives on a single beat, along with a 6-bit quantization parameter (QP) and a flag that marks the block as intra or inter. Each coefficient is quantized on its magnitude. The magnitude is multiplied by a constant chosen by the coefficient's position and by QP mod 6. A rounding offset is added, and the sum is shifted right by 15 + QP/6. The input sign is then put back on the result.

Because QP/6 sets the shift, the effective step size doubles for every increase of six in QP. The six multiplier rows give the fractional steps in between. QP values above 51 are clamped to 51, and the matching output beat is flagged. The result appears two clock edges after the input beat, with a valid strobe aligned to it.

Top module: `qz_quant4x4`

## Requirements
- R1: A QP above 51 is quantized as QP 51, and `out_qp_clamped` is high on that beat's output. For QP 0..51 it is low.
- R2: For clamped QP q, each output magnitude is floor((|c|*M + F) / 2^(15 + q/6)), and the output carries the sign of c.
- R3: M depends on q mod 6 (index 0..5) and on the position class of coefficient i. Coefficient i sits at `in_coefs[16*i +: 16]`, with row = i/4 and column = i%4. For class E (row and column both even) M is 13107, 11916, 10082, 9362, 8192, 7282. For class O (both odd) M is 5243, 4660, 4194, 3647, 3355, 2893. For class X (mixed parity) M is 8066, 7490, 6554, 5825, 5243, 4559.
- R4: F is floor(2^(15+q/6)/3) when `in_intra` is 1 and floor(2^(15+q/6)/6) when it is 0.
- R5: A zero coefficient always yields a zero level.
- R6: A negative coefficient never yields a positive level, and a positive one never yields a negative level. The input -32768 is handled as magnitude 32768.
- R7: `out_valid` is high exactly two rising edges after a rising edge that sampled `in_valid` high, and low otherwise. `out_levels` changes only together with a valid output and holds its value otherwise.
- R8: While reset is held, and after it until the first valid output, `out_valid` and `out_qp_clamped` are 0 and all levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat strobe |
| in_coefs | input | 256 | Sixteen signed 16-bit coefficients, index i at bits 16*i upward |
| in_qp | input | 6 | Quantization parameter, 0..63 accepted, clamped to 51 |
| in_intra | input | 1 | 1 selects the intra rounding offset, 0 the inter offset |
| out_valid | output | 1 | Output beat strobe, two cycles after the input |
| out_levels | output | 256 | Sixteen signed 16-bit levels, same indexing as the input |
| out_qp_clamped | output | 1 | The QP of this output beat was above 51 |

## Verification
The bench drives the extreme magnitudes 32767 and -32768 at QP 0, where the product is widest. A missing product bit or a wrong absolute value there would give wrapped or sign-flipped levels. It sweeps QP over 0..63 back to back, so each multiplier row and every shift from 15 to 23 is used. A wrong table row, a shift that is off by one, or missing clamping would show as halved or doubled levels above QP 51. Small values near the rounding points, sent as both intra and inter, expose an offset that has been swapped or computed against the wrong shift. Randomly gapped valid beats check that levels hold between beats and that the valid strobe is neither late nor early.

// File: rtl/qz_pkg.sv
`timescale 1ns/1ps
package qz_pkg;

   localparam int MF_W = 14;

   typedef enum logic [1:0] {
      POS_EVEN = 2'd0,
      POS_ODD  = 2'd1,
      POS_MIX  = 2'd2
   } pos_class_e;

   // Position class of lane idx in a row-major 4x4 block.
   function automatic pos_class_e class_of(input int idx);
      int row;
      int col;
      row = idx / 4;
      col = idx % 4;
      if ((row % 2 == 0) && (col % 2 == 0)) return POS_EVEN;
      if ((row % 2 == 1) && (col % 2 == 1)) return POS_ODD;
      return POS_MIX;
   endfunction

   // Combined scale/step multiplier by QP remainder and class.
   function automatic logic [MF_W-1:0] mf_lookup(input logic [2:0] rem,
                                                 input pos_class_e cls);
      logic [MF_W-1:0] ev;
      logic [MF_W-1:0] od;
      logic [MF_W-1:0] mx;
      unique case (rem)
         3'd0:    begin ev = 14'd13107; od = 14'd5243; mx = 14'd8066; end
         3'd1:    begin ev = 14'd11916; od = 14'd4660; mx = 14'd7490; end
         3'd2:    begin ev = 14'd10082; od = 14'd4194; mx = 14'd6554; end
         3'd3:    begin ev = 14'd9362;  od = 14'd3647; mx = 14'd5825; end
         3'd4:    begin ev = 14'd8192;  od = 14'd3355; mx = 14'd5243; end
         default: begin ev = 14'd7282;  od = 14'd2893; mx = 14'd4559; end
      endcase
      unique case (cls)
         POS_EVEN: return ev;
         POS_ODD:  return od;
         default:  return mx;
      endcase
   endfunction

endpackage

// File: rtl/qz_step_decode.sv
`timescale 1ns/1ps
module qz_step_decode #(
   parameter int QP_W       = 6,
   parameter int QP_MAX     = 51,
   parameter int SHIFT_BASE = 15,
   parameter int SHIFT_W    = 5,
   parameter int OFF_W      = 23
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [QP_W-1:0]    in_qp,
   input  logic               in_intra,
   output logic               s1_valid,
   output logic [2:0]         s1_rem,
   output logic [SHIFT_W-1:0] s1_qbits,
   output logic [OFF_W-1:0]   s1_offset,
   output logic               s1_clamped
);

   localparam int QB_MAX = SHIFT_BASE + QP_MAX / 6;
   localparam int UNIT_W = QB_MAX + 1;

   if (QP_W < 3) begin : g_bad_qpw
      $error("qz_step_decode: QP_W must be at least 3");
   end
   if (OFF_W < QB_MAX - 1) begin : g_bad_offw
      $error("qz_step_decode: OFF_W too narrow for the rounding offset");
   end

   logic              over_c;
   logic [QP_W-1:0]   qp_c;
   logic [2:0]        rem_c;
   logic [SHIFT_W-1:0] qbits_c;
   logic [UNIT_W-1:0] unit_c;
   logic [OFF_W-1:0]  off_c;

   always_comb begin
      over_c  = (in_qp > QP_W'(QP_MAX));
      qp_c    = over_c ? QP_W'(QP_MAX) : in_qp;
      rem_c   = 3'(qp_c % QP_W'(6));
      qbits_c = SHIFT_W'(SHIFT_BASE) + SHIFT_W'(qp_c / QP_W'(6));
      unit_c  = UNIT_W'(1) << qbits_c;
      off_c   = in_intra ? OFF_W'(unit_c / UNIT_W'(3)) : OFF_W'(unit_c / UNIT_W'(6));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid   <= 1'b0;
         s1_rem     <= '0;
         s1_qbits   <= SHIFT_W'(SHIFT_BASE);
         s1_offset  <= '0;
         s1_clamped <= 1'b0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_rem     <= rem_c;
            s1_qbits   <= qbits_c;
            s1_offset  <= off_c;
            s1_clamped <= over_c;
         end
      end
   end

   // R1
   qp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_qp > QP_W'(QP_MAX))) |=> (s1_clamped && (s1_qbits == SHIFT_W'(QB_MAX))));

   // R7
   stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);

   // R7
   stage_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !s1_valid);

endmodule

// File: rtl/qz_lane.sv
`timescale 1ns/1ps
module qz_lane
   import qz_pkg::*;
#(
   parameter int COEF_W  = 16,
   parameter int LEVEL_W = 16,
   parameter int POS     = 0,
   parameter int SHIFT_W = 5,
   parameter int OFF_W   = 23
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [COEF_W-1:0]  coef,
   input  logic               s1_valid,
   input  logic [2:0]         s1_rem,
   input  logic [SHIFT_W-1:0] s1_qbits,
   input  logic [OFF_W-1:0]   s1_offset,
   output logic [LEVEL_W-1:0] level
);

   localparam pos_class_e CLS  = class_of(POS);
   localparam int PROD_W = COEF_W + MF_W;
   localparam int SUM_W  = ((PROD_W > OFF_W) ? PROD_W : OFF_W) + 1;

   if (POS < 0 || POS > 15) begin : g_bad_pos
      $error("qz_lane: POS must be 0..15");
   end

   logic [COEF_W-1:0]  mag_q;
   logic               neg_q;
   logic [MF_W-1:0]    mf_c;
   logic [PROD_W-1:0]  prod_c;
   logic [SUM_W-1:0]   sum_c;
   logic [LEVEL_W-1:0] mag_lvl_c;
   logic [LEVEL_W-1:0] lvl_c;

   // Stage 1: sign and magnitude split.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else if (in_valid) begin
         neg_q <= coef[COEF_W-1];
         mag_q <= coef[COEF_W-1] ? (~coef + 1'b1) : coef;
      end
   end

   // Stage 2: one multiply, offset, one shift, sign restore.
   always_comb begin
      mf_c      = mf_lookup(s1_rem, CLS);
      prod_c    = PROD_W'(mag_q) * PROD_W'(mf_c);
      sum_c     = SUM_W'(prod_c) + SUM_W'(s1_offset);
      mag_lvl_c = LEVEL_W'(sum_c >> s1_qbits);
      lvl_c     = neg_q ? (~mag_lvl_c + 1'b1) : mag_lvl_c;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else if (s1_valid) begin
         level <= lvl_c;
      end
   end

   // R5
   zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && (mag_q == '0)) |=> (level == '0));

   // R6
   neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && neg_q) |=> (level[LEVEL_W-1] || (level == '0)));

   // R6
   pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !neg_q) |=> !level[LEVEL_W-1]);

   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(level));

endmodule

// File: rtl/qz_quant4x4.sv
`timescale 1ns/1ps
module qz_quant4x4 #(
   parameter int COEF_W     = 16,
   parameter int LEVEL_W    = 16,
   parameter int QP_W       = 6,
   parameter int QP_MAX     = 51,
   parameter int SHIFT_BASE = 15
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [16*COEF_W-1:0]  in_coefs,
   input  logic [QP_W-1:0]       in_qp,
   input  logic                  in_intra,
   output logic                  out_valid,
   output logic [16*LEVEL_W-1:0] out_levels,
   output logic                  out_qp_clamped
);

   localparam int LANES   = 16;
   localparam int QB_MAX  = SHIFT_BASE + QP_MAX / 6;
   localparam int SHIFT_W = $clog2(QB_MAX + 1);
   localparam int OFF_W   = QB_MAX;

   if (LEVEL_W < COEF_W) begin : g_bad_lvl
      $error("qz_quant4x4: LEVEL_W must be at least COEF_W");
   end
   if (QP_MAX >= (1 << QP_W)) begin : g_bad_qpmax
      $error("qz_quant4x4: QP_MAX does not fit in QP_W bits");
   end
   if (SHIFT_BASE < 1) begin : g_bad_base
      $error("qz_quant4x4: SHIFT_BASE must be positive");
   end

   logic               s1_valid;
   logic [2:0]         s1_rem;
   logic [SHIFT_W-1:0] s1_qbits;
   logic [OFF_W-1:0]   s1_offset;
   logic               s1_clamped;

   qz_step_decode #(
      .QP_W       (QP_W),
      .QP_MAX     (QP_MAX),
      .SHIFT_BASE (SHIFT_BASE),
      .SHIFT_W    (SHIFT_W),
      .OFF_W      (OFF_W)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_qp      (in_qp),
      .in_intra   (in_intra),
      .s1_valid   (s1_valid),
      .s1_rem     (s1_rem),
      .s1_qbits   (s1_qbits),
      .s1_offset  (s1_offset),
      .s1_clamped (s1_clamped)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      qz_lane #(
         .COEF_W  (COEF_W),
         .LEVEL_W (LEVEL_W),
         .POS     (i),
         .SHIFT_W (SHIFT_W),
         .OFF_W   (OFF_W)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (in_valid),
         .coef      (in_coefs[i*COEF_W +: COEF_W]),
         .s1_valid  (s1_valid),
         .s1_rem    (s1_rem),
         .s1_qbits  (s1_qbits),
         .s1_offset (s1_offset),
         .level     (out_levels[i*LEVEL_W +: LEVEL_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_qp_clamped <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_qp_clamped <= s1_clamped;
      end
   end

   // R7
   out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);

   // R7
   out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid);

   // R1
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(out_qp_clamped));

endmodule

// File: tb/qz_quant4x4_test.sv
`timescale 1ns/1ps
module qz_quant4x4_test;

   localparam int N  = 16;
   localparam int CW = 16;
   localparam int LW = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [N*CW-1:0] in_coefs = '0;
   logic [5:0]     in_qp = '0;
   logic           in_intra = 1'b0;
   logic           out_valid;
   logic [N*LW-1:0] out_levels;
   logic           out_qp_clamped;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qz_quant4x4 uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_coefs       (in_coefs),
      .in_qp          (in_qp),
      .in_intra       (in_intra),
      .out_valid      (out_valid),
      .out_levels     (out_levels),
      .out_qp_clamped (out_qp_clamped)
   );

   typedef struct {
      int lv[N];
      int cf[N];
      bit clamp;
   } beat_t;

   beat_t q[$];
   int    held[N];
   bit    vh1 = 1'b0;
   bit    vh2 = 1'b0;

   // Reference: clamp, table by remainder/class, offset, shift, sign.
   function automatic int ref_level(int c, int qp, bit intra, int pos);
      int mfe[6] = '{13107, 11916, 10082, 9362, 8192, 7282};
      int mfo[6] = '{5243, 4660, 4194, 3647, 3355, 2893};
      int mfm[6] = '{8066, 7490, 6554, 5825, 5243, 4559};
      int qq;
      int qb;
      int row;
      int col;
      longint m;
      longint f;
      longint mag;
      longint v;
      qq  = (qp > 51) ? 51 : qp;
      qb  = 15 + qq / 6;
      row = pos / 4;
      col = pos % 4;
      if (row % 2 == 0 && col % 2 == 0)      m = mfe[qq % 6];
      else if (row % 2 == 1 && col % 2 == 1) m = mfo[qq % 6];
      else                                   m = mfm[qq % 6];
      f   = (longint'(1) << qb) / (intra ? 3 : 6);
      mag = (c < 0) ? -longint'(c) : longint'(c);
      v   = (mag * m + f) >> qb;
      return (c < 0) ? -int'(v) : int'(v);
   endfunction

   function automatic int lane_out(int i);
      return int'($signed(out_levels[i*LW +: LW]));
   endfunction

   // Capture expected beats at the edge that samples the inputs.
   always @(posedge clk) begin
      if (!rst_n) begin
         vh1 <= 1'b0;
         vh2 <= 1'b0;
      end else begin
         vh2 <= vh1;
         vh1 <= in_valid;
         if (in_valid) begin
            beat_t b;
            for (int i = 0; i < N; i++) begin
               b.cf[i] = int'($signed(in_coefs[i*CW +: CW]));
               b.lv[i] = ref_level(b.cf[i], int'(in_qp), in_intra, i);
            end
            b.clamp = (in_qp > 6'd51);
            q.push_back(b);
         end
      end
   end

   // Compare on every falling edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         beat_t b;
         int a;
         checks++;
         if (out_valid !== vh2) begin
            failures++;
            $display("FAIL R7 out_valid actual=%0b expected=%0b", out_valid, vh2);
         end
         if (out_valid === 1'b1 && q.size() > 0) begin
            b = q.pop_front();
            checks++;
            if (out_qp_clamped !== b.clamp) begin
               failures++;
               $display("FAIL R1 clamp flag actual=%0b expected=%0b", out_qp_clamped, b.clamp);
            end
            for (int i = 0; i < N; i++) begin
               a = lane_out(i);
               checks++;
               if (a != b.lv[i]) begin
                  failures++;
                  if (b.cf[i] == 0)
                     $display("FAIL R5 lane %0d actual=%0d expected=%0d", i, a, b.lv[i]);
                  else if ((b.cf[i] < 0 && a > 0) || (b.cf[i] > 0 && a < 0))
                     $display("FAIL R6 lane %0d actual=%0d expected=%0d", i, a, b.lv[i]);
                  else
                     $display("FAIL R2 lane %0d coef=%0d actual=%0d expected=%0d",
                              i, b.cf[i], a, b.lv[i]);
               end
               held[i] = b.lv[i];
            end
         end else begin
            for (int i = 0; i < N; i++) begin
               a = lane_out(i);
               checks++;
               if (a != held[i]) begin
                  failures++;
                  $display("FAIL R7 hold lane %0d actual=%0d expected=%0d", i, a, held[i]);
               end
            end
         end
      end
   end

   task automatic send(input int c[N], input int qp, input bit intra);
      @(negedge clk);
      in_valid = 1'b1;
      in_qp    = 6'(qp);
      in_intra = intra;
      for (int i = 0; i < N; i++) in_coefs[i*CW +: CW] = CW'(c[i]);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   initial begin
      int c[N];
      for (int i = 0; i < N; i++) held[i] = 0;
      repeat (3) @(negedge clk);
      // R8 reset state while reset is held
      checks++;
      if (out_valid !== 1'b0 || out_qp_clamped !== 1'b0 || out_levels !== '0) begin
         failures++;
         $display("FAIL R8 reset outputs actual=%0b/%0b/%h expected=0/0/0",
                  out_valid, out_qp_clamped, out_levels);
      end
      rst_n = 1'b1;
      idle(3);

      // R5 all-zero block, intra and inter
      for (int i = 0; i < N; i++) c[i] = 0;
      send(c, 28, 1'b1);
      send(c, 28, 1'b0);

      // R3 alternating-sign ramp touches every position class
      for (int i = 0; i < N; i++) c[i] = ((i % 2) ? -1 : 1) * (i * 37 + 5);
      send(c, 0, 1'b1);
      send(c, 0, 1'b0);
      send(c, 17, 1'b1);
      idle(2);
      send(c, 51, 1'b0);

      // R6 extreme magnitudes at the widest product
      for (int i = 0; i < N; i++) c[i] = -32768;
      send(c, 0, 1'b1);
      for (int i = 0; i < N; i++) c[i] = 32767;
      send(c, 0, 1'b1);
      for (int i = 0; i < N; i++) c[i] = (i % 3 == 0) ? -32768 : 32767 - i;
      send(c, 51, 1'b0);
      idle(1);

      // R1 clamping above 51
      for (int i = 0; i < N; i++) c[i] = 3000 - 411 * i;
      send(c, 51, 1'b1);
      send(c, 52, 1'b1);
      send(c, 63, 1'b0);
      idle(2);

      // R4 small values near the rounding points, intra vs inter
      for (int i = 0; i < N; i++) c[i] = i - 8;
      send(c, 0, 1'b1);
      send(c, 0, 1'b0);
      for (int i = 0; i < N; i++) c[i] = 4 * (i - 8) + 1;
      send(c, 6, 1'b1);
      send(c, 6, 1'b0);
      idle(1);

      // R2 sweep of every QP code back to back
      for (int i = 0; i < N; i++) c[i] = ((i % 2) ? 1 : -1) * (1000 + 97 * i);
      for (int qp = 0; qp < 64; qp++) send(c, qp, qp[0]);
      idle(3);

      // R7 random beats with gaps
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 10 < 3) idle(1 + int'($urandom % 3));
         for (int i = 0; i < N; i++)
            c[i] = ($urandom % 4 == 0) ? int'($signed(16'($urandom)))
                                       : int'($urandom % 41) - 20;
         send(c, int'($urandom % 64), 1'($urandom));
      end
      idle(6);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL R7 watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule